// File: doc/BRIEF.md
# Profiling Event Counter Bank

This block holds five small counters that measure where a processor core spends its cycles. The counters cover extra execution cycles, exception-handling overhead, sleep time, extra load/store cycles and zero-cycle (folded) instructions. The core supplies per-cycle strobes, and the block decides from them whether each counter advances in that cycle. When a counter passes 255 it wraps to 0 and sends a one-cycle event pulse. Trace logic elsewhere can use that pulse as a coarse profiling sample.

Software reaches the bank through one narrow register port. Address 0 holds the five enable bits, and addresses 1 to 5 hold the counter values. Setting an enable bit restarts its counter from zero. A static strap input marks the counters as not present, and while it is set every counter is frozen. The block runs entirely on the free-running clock, so it keeps counting sleep cycles while the core is idle.

Top module: `prof_evt_bank`

## Requirements
- R1: After reset all enable bits are 0, every counter reads 0 and `evt_o` is 0.
- R2: Register map. Address 0 reads the enable bits in data bits [4:0], with bit i enabling counter i, and 0 above them. Address 1+i reads and writes counter i. The counter order is 0 extra-cycle, 1 exception, 2 sleep, 3 load/store and 4 folded. Addresses 6 and 7 read 0. Reads are combinational on `reg_addr`.
- R3: A write that changes an enable bit from 0 to 1 sets that counter to 0 at the same clock edge. Rewriting a bit that is already 1 leaves the counter unchanged.
- R4: An enabled counter rises by exactly 1 at each clock edge whose cycle has its qualifier true. It holds its value when disabled or when its qualifier is false.
- R5: The extra-cycle qualifier is (`exe_busy_i` and not `exe_first_i`) or `fetch_stall_i`. A two-cycle instruction therefore adds 1, and each fetch stall cycle adds 1.
- R6: The load/store qualifier is `lsu_busy_i` and not `lsu_first_i`. A two-cycle load adds 1, and a four-cycle load adds 3.
- R7: The exception, sleep and folded counters advance in each cycle that `exc_busy_i`, `sleep_i` or `fold_i` is high, respectively.
- R8: An increment from 255 wraps the counter to 0. In the following cycle `evt_o[i]` is high for exactly one cycle, the same cycle in which the counter first reads 0.
- R9: A software write to a counter wins over an increment in the same cycle and never produces an event, even if the counter held 255 and its qualifier was true.
- R10: While `no_perf_i` is 1, no counter increments and `evt_o` stays 0. Register writes still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| no_perf_i | input | 1 | Strap: counters not present, hold them inert |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| exe_busy_i | input | 1 | Non-load/store instruction occupies this cycle |
| exe_first_i | input | 1 | This is that instruction's first cycle |
| fetch_stall_i | input | 1 | Instruction fetch stall cycle |
| exc_busy_i | input | 1 | Exception entry, return or pre-emption cycle |
| sleep_i | input | 1 | Core is sleeping this cycle |
| lsu_busy_i | input | 1 | Load/store instruction occupies this cycle |
| lsu_first_i | input | 1 | This is that load/store's first cycle |
| fold_i | input | 1 | A folded instruction retires this cycle |
| evt_o | output | 5 | Per-counter overflow event pulses |

## Verification
The assertions assume that `no_perf_i` and the strobes are stable around the rising edge. They also assume that at most one register write arrives per cycle, so an enable-driven clear and a counter write can never target the same counter together. The bench drives all inputs on the falling edge and issues one write per call. It draws the strobes freely from $urandom, including first-cycle flags without busy flags, and the reference model gives such cycles no count. Directed cases place counters next to 255 and open the clear, priority and strap windows on purpose.

// File: rtl/prof_pkg.sv
package prof_pkg;
  localparam int unsigned NUM_CNT = 5;
  typedef enum int unsigned {
    IDX_XCYC = 0,
    IDX_EXC  = 1,
    IDX_SLP  = 2,
    IDX_LSU  = 3,
    IDX_FOLD = 4
  } ctr_idx_e;
endpackage

// File: rtl/prof_qual.sv
module prof_qual
  import prof_pkg::*;
(
  input  logic               exe_busy_i,
  input  logic               exe_first_i,
  input  logic               fetch_stall_i,
  input  logic               exc_busy_i,
  input  logic               sleep_i,
  input  logic               lsu_busy_i,
  input  logic               lsu_first_i,
  input  logic               fold_i,
  output logic [NUM_CNT-1:0] qual_o
);
  always_comb begin
    qual_o           = '0;
    qual_o[IDX_XCYC] = (exe_busy_i & ~exe_first_i) | fetch_stall_i;
    qual_o[IDX_EXC]  = exc_busy_i;
    qual_o[IDX_SLP]  = sleep_i;
    qual_o[IDX_LSU]  = lsu_busy_i & ~lsu_first_i;
    qual_o[IDX_FOLD] = fold_i;
  end
endmodule

// File: rtl/prof_ctr.sv
module prof_ctr #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         evt_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;
  logic         evt_q, evt_d;
  logic         upd;

  always_comb begin
    cnt_d = cnt_q;
    evt_d = 1'b0;
    if (clr_i) begin
      cnt_d = '0;
    end else if (wr_i) begin
      cnt_d = wdata_i;
    end else if (inc_i) begin
      cnt_d = cnt_q + 1'b1;
      evt_d = (cnt_q == CNT_MAX);
    end
  end

  assign upd = clr_i | wr_i | inc_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      evt_q <= 1'b0;
    end else begin
      evt_q <= evt_d;
      if (upd) cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;
  assign evt_o = evt_q;

  // R9
  wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !clr_i) |=> (cnt_q == $past(wdata_i)) && !evt_q);
  // R8
  evt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_q) |-> (cnt_q == '0));
  // R3
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !wr_i && !inc_i) |=> $stable(cnt_q));
  // R4
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i && !wr_i) |=> (cnt_q == W'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/prof_evt_bank.sv
module prof_evt_bank
  import prof_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              no_perf_i,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  input  logic              exe_busy_i,
  input  logic              exe_first_i,
  input  logic              fetch_stall_i,
  input  logic              exc_busy_i,
  input  logic              sleep_i,
  input  logic              lsu_busy_i,
  input  logic              lsu_first_i,
  input  logic              fold_i,
  output logic [NUM_CNT-1:0] evt_o
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;

  logic [NUM_CNT-1:0] ctrl_q, ctrl_d;
  logic               ctrl_wr;
  logic [NUM_CNT-1:0] qual, inc, clr, cwr;
  logic [CNT_W-1:0]   cnt [NUM_CNT];

  prof_qual u_qual (
    .exe_busy_i   (exe_busy_i),
    .exe_first_i  (exe_first_i),
    .fetch_stall_i(fetch_stall_i),
    .exc_busy_i   (exc_busy_i),
    .sleep_i      (sleep_i),
    .lsu_busy_i   (lsu_busy_i),
    .lsu_first_i  (lsu_first_i),
    .fold_i       (fold_i),
    .qual_o       (qual)
  );

  assign ctrl_wr = reg_we && (reg_addr == CTRL_ADDR);

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) ctrl_d = reg_wdata[NUM_CNT-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_d;
  end

  assign clr = {NUM_CNT{ctrl_wr}} & reg_wdata[NUM_CNT-1:0] & ~ctrl_q;
  assign inc = ctrl_q & qual & {NUM_CNT{~no_perf_i}};

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_ctr
    assign cwr[i] = reg_we && (reg_addr == ADDR_W'(i + 1));
    prof_ctr #(.W(CNT_W)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr[i]),
      .wr_i   (cwr[i]),
      .wdata_i(reg_wdata),
      .inc_i  (inc[i]),
      .cnt_o  (cnt[i]),
      .evt_o  (evt_o[i])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CTRL_ADDR) reg_rdata[NUM_CNT-1:0] = ctrl_q;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (reg_addr == ADDR_W'(i + 1)) reg_rdata = cnt[i];
    end
  end

  // R10
  strap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    no_perf_i |=> (evt_o == '0));
  // R3
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (ctrl_q == $past(reg_wdata[NUM_CNT-1:0])));
  // R8
  evt_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q == '0) |=> (evt_o == '0));
endmodule

// File: tb/prof_evt_bank_tb.sv
module prof_evt_bank_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       no_perf_i;
  logic       reg_we;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       exe_busy_i, exe_first_i, fetch_stall_i, exc_busy_i;
  logic       sleep_i, lsu_busy_i, lsu_first_i, fold_i;
  logic [4:0] evt_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] mcnt [5];
  logic [4:0] mctl;
  logic [4:0] mevt;
  logic       strap;

  always #10 clk = ~clk;

  prof_evt_bank u_dut (
    .clk(clk), .rst_n(rst_n), .no_perf_i(no_perf_i),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .exe_busy_i(exe_busy_i), .exe_first_i(exe_first_i), .fetch_stall_i(fetch_stall_i),
    .exc_busy_i(exc_busy_i), .sleep_i(sleep_i), .lsu_busy_i(lsu_busy_i),
    .lsu_first_i(lsu_first_i), .fold_i(fold_i), .evt_o(evt_o)
  );

  // q bits: 0 exe_busy, 1 exe_first, 2 fetch_stall, 3 exc, 4 sleep, 5 lsu_busy, 6 lsu_first, 7 fold
  function automatic logic [4:0] qual_of(input logic [7:0] q);
    qual_of[0] = (q[0] & ~q[1]) | q[2];
    qual_of[1] = q[3];
    qual_of[2] = q[4];
    qual_of[3] = q[5] & ~q[6];
    qual_of[4] = q[7];
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [2:0] a, input logic [7:0] d, input logic [7:0] q);
    logic [4:0] qm;
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = d; no_perf_i = strap;
    {fold_i, lsu_first_i, lsu_busy_i, sleep_i, exc_busy_i, fetch_stall_i, exe_first_i, exe_busy_i} = q;
    qm = qual_of(q);
    mevt = '0;
    for (int i = 0; i < 5; i++) begin
      if (we && a == 3'd0 && d[i] && !mctl[i]) mcnt[i] = 8'd0;
      else if (we && a == 3'(i + 1)) mcnt[i] = d;
      else if (mctl[i] && !strap && qm[i]) begin
        if (mcnt[i] == 8'hFF) mevt[i] = 1'b1;
        mcnt[i] = mcnt[i] + 8'd1;
      end
    end
    if (we && a == 3'd0) mctl = d[4:0];
    @(posedge clk);
    #1;
    chk("R8 evt", int'(evt_o), int'(mevt));
  endtask

  task automatic rd_all(input string req);
    reg_we = 1'b0;
    for (int i = 0; i < 6; i++) begin
      reg_addr = 3'(i);
      #1;
      if (i == 0) chk(req, int'(reg_rdata), int'({3'b000, mctl}));
      else        chk(req, int'(reg_rdata), int'(mcnt[i-1]));
    end
  endtask

  task automatic rd_one(input string req, input logic [2:0] a, input int exp);
    reg_we = 1'b0; reg_addr = a; #1;
    chk(req, int'(reg_rdata), exp);
  endtask

  initial begin
    int unsigned seed_v;
    logic [7:0] base;
    seed_v = $urandom(32'h5EED1234);
    strap = 1'b0; mctl = '0; mevt = '0;
    for (int i = 0; i < 5; i++) mcnt[i] = '0;
    rst_n = 1'b0; no_perf_i = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    {fold_i, lsu_first_i, lsu_busy_i, sleep_i, exc_busy_i, fetch_stall_i, exe_first_i, exe_busy_i} = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 evt", int'(evt_o), 0);
    rd_all("R1");

    // R2 unmapped addresses read zero
    rd_one("R2 addr6", 3'd6, 0);
    rd_one("R2 addr7", 3'd7, 0);

    // R3 enabling clears, disabled counter holds written value
    cyc(1'b1, 3'd2, 8'h44, 8'h00);
    cyc(1'b0, 3'd0, 8'h00, 8'h08);
    rd_one("R4 disabled hold", 3'd2, 'h44);
    cyc(1'b1, 3'd0, 8'h1F, 8'h00);
    rd_one("R3 clear on enable", 3'd2, 0);
    rd_all("R2");

    // R6 four-cycle load adds 3, two-cycle adds 1
    cyc(1'b0, 3'd0, 8'h00, 8'h60);
    repeat (3) cyc(1'b0, 3'd0, 8'h00, 8'h20);
    rd_one("R6 four-cycle load", 3'd4, 3);
    cyc(1'b0, 3'd0, 8'h00, 8'h60);
    cyc(1'b0, 3'd0, 8'h00, 8'h20);
    rd_one("R6 two-cycle load", 3'd4, 4);

    // R5 two-cycle instruction adds 1, a fetch stall adds 1
    cyc(1'b0, 3'd0, 8'h00, 8'h03);
    cyc(1'b0, 3'd0, 8'h00, 8'h01);
    rd_one("R5 two-cycle instr", 3'd1, 1);
    cyc(1'b0, 3'd0, 8'h00, 8'h06);
    rd_one("R5 fetch stall", 3'd1, 2);

    // R7 exception, sleep, fold strobes
    cyc(1'b0, 3'd0, 8'h00, 8'h98);
    cyc(1'b0, 3'd0, 8'h00, 8'h10);
    rd_one("R7 exc", 3'd2, 1);
    rd_one("R7 sleep", 3'd3, 2);
    rd_one("R7 fold", 3'd5, 1);

    // R3 rewriting a set bit keeps value
    cyc(1'b1, 3'd0, 8'h1F, 8'h00);
    rd_one("R3 no clear on rewrite", 3'd3, 2);

    // R8 wrap of the fold counter
    cyc(1'b1, 3'd5, 8'hFE, 8'h00);
    cyc(1'b0, 3'd0, 8'h00, 8'h80);
    chk("R8 no evt at 255", int'(evt_o[4]), 0);
    cyc(1'b0, 3'd0, 8'h00, 8'h80);
    chk("R8 evt on wrap", int'(evt_o[4]), 1);
    rd_one("R8 wrapped zero", 3'd5, 0);
    cyc(1'b0, 3'd0, 8'h00, 8'h00);
    chk("R8 single pulse", int'(evt_o[4]), 0);

    // R9 write beats increment at 255
    cyc(1'b1, 3'd5, 8'hFF, 8'h00);
    cyc(1'b1, 3'd5, 8'h07, 8'h80);
    chk("R9 no evt on write", int'(evt_o), 0);
    rd_one("R9 write wins", 3'd5, 7);

    // R10 strap freezes counting, writes still land
    strap = 1'b1;
    cyc(1'b1, 3'd3, 8'hFF, 8'h00);
    for (int n = 0; n < 200; n++) cyc(1'b0, 3'd0, 8'h00, 8'($urandom));
    chk("R10 strap evt", int'(evt_o), 0);
    rd_all("R10");
    cyc(1'b1, 3'd4, 8'h5A, 8'hFF);
    rd_one("R10 write lands", 3'd4, 'h5A);
    strap = 1'b0;

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] a;
      a = 3'($urandom % 6);
      if (($urandom % 16) == 0) begin
        base = (a == 3'd0) ? 8'($urandom | 32'h18) : 8'(8'hF0 | $urandom);
        cyc(1'b1, a, base, 8'($urandom));
      end else begin
        cyc(1'b0, 3'd0, 8'h00, 8'($urandom));
      end
      if ((n % 50) == 49) rd_all("R4");
    end
    rd_all("R4 final");

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog got=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule